// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block reads a ring of 8-byte transmit descriptors from memory and turns each ready descriptor into one buffer segment for a downstream frame assembler. A start pulse begins a pass only while the controller enable input is high. A pass fetches descriptors one at a time from the current ring position. For each descriptor whose ready flag is set it emits a segment (buffer pointer, clipped length, end-of-frame mark), writes the descriptor back with the ready flag cleared, raises per-buffer and per-frame events, and then steps to the next slot. The pass ends at the first descriptor that is not ready, and the ring position stays there for the next start.

Memory is reached through a single request channel with valid/ready and a separate read-response strobe. A request holds its address, direction and write data stable until it is accepted. A write is complete at acceptance. A read returns exactly one response on a later cycle, and only one read is outstanding at a time. The segment output is also valid/ready: once `seg_valid` is raised, pointer, length and end mark hold still until `seg_ready` is seen. The walker stalls without limit on either channel. The ring base is loaded through a plain write strobe.

Descriptor layout (64 bits as returned by memory): bits [15:0] flags, bits [31:16] buffer length in bytes, bits [63:32] buffer pointer. In the flags, bit 15 is ready, bit 13 is wrap and bit 11 is last.

Top module: `txw_ring_walker`

## Requirements
- R1: A pass stops at the first fetched descriptor whose flag bit 15 (ready) is clear. That descriptor gets no segment, no write-back and no event. Its address is kept, so the next pass fetches it first.
- R2: Segment lengths add up within a frame. When a descriptor's length exceeds the room left below MAX_FRAME, the segment length is cut to that room (possibly zero) and `evt_babble` pulses for one cycle.
- R3: A descriptor with flag bit 11 (last) drives `seg_last` high, pulses `evt_frame_done` and resets the running frame length to zero.
- R4: Every processed descriptor is written back to the address it was read from, with bit 15 cleared and every other bit unchanged. `evt_buf_done` pulses once, in the cycle after the write-back is accepted.
- R5: After a descriptor with flag bit 13 (wrap), the next fetch address is the ring base. Otherwise it is the current address plus 8.
- R6: A ring-base write stores the value with bits [1:0] forced to zero and moves the current fetch address to that value.
- R7: A start pulse while `ctrl_enable` is low has no effect: no memory request follows.
- R8: A start pulse that arrives while a pass runs is remembered, and exactly one more pass runs after the current one ends.
- R9: `seg_ptr` equals the descriptor's bits [63:32]. With no clipping, `seg_len` equals bits [31:16].
- R10: While `seg_valid` or `mem_req_valid` is high and not accepted, the signal stays high and its payload is stable.
- R11: After reset the block is idle: `busy`, `seg_valid`, `mem_req_valid` and all event outputs are low, and the ring base and fetch address are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_enable | input | 1 | Controller enable; gates start pulses |
| start_pulse | input | 1 | Request a pass over the ring |
| base_wr_en | input | 1 | Ring-base write strobe |
| base_wr_data | input | ADDR_W | Ring-base value to write |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = descriptor write-back, 0 = descriptor fetch |
| mem_req_addr | output | ADDR_W | Descriptor address |
| mem_req_wdata | output | 64 | Write-back data |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_rdata | input | 64 | Fetched descriptor |
| seg_valid | output | 1 | Segment valid |
| seg_ready | input | 1 | Segment accepted by the assembler |
| seg_ptr | output | 32 | Buffer pointer |
| seg_len | output | 16 | Clipped buffer length |
| seg_last | output | 1 | Segment closes a frame |
| evt_buf_done | output | 1 | Pulse: one descriptor processed |
| evt_frame_done | output | 1 | Pulse: frame-closing descriptor processed |
| evt_babble | output | 1 | Pulse: segment was clipped |
| busy | output | 1 | A pass is in progress |

## Verification
A wrong fetch address shows up as a fetch to an unexpected address as soon as the next descriptor is fetched. A lost pending start or a missed stop shows up as a missing or extra fetch when a pass ends. A wrong frame-length accumulator does not show on the current segment. It shows as a wrong `seg_len` or a missing or spurious `evt_babble` on a later descriptor of the same frame, or at the first descriptor of the next frame if a last flag failed to clear it. A wrong write-back shows up in the written data at the write-back itself, one segment handshake after the fetch.

// File: rtl/txw_pkg.sv
package txw_pkg;
  localparam int PTR_W  = 32;
  localparam int LEN_W  = 16;
  localparam int FLAG_W = 16;
  localparam int DESC_W = PTR_W + LEN_W + FLAG_W;

  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;

  typedef struct packed {
    logic [PTR_W-1:0]  ptr;
    logic [LEN_W-1:0]  len;
    logic [FLAG_W-1:0] flags;
  } txw_desc_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_SEG,
    ST_WB
  } txw_state_e;
endpackage

// File: rtl/txw_start_ctl.sv
module txw_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_enable,
  input  logic start_pulse,
  input  logic take,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pending <= 1'b0;
    else if (!ctrl_enable)
      pending <= 1'b0;
    else if (start_pulse)
      pending <= 1'b1;
    else if (take)
      pending <= 1'b0;
  end

  // R7: a disabled controller never holds a start
  a_r7_no_pending_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_enable |=> !pending);

  // R8: an enabled start is always remembered
  a_r8_start_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (start_pulse && ctrl_enable) |=> pending);
endmodule

// File: rtl/txw_addr_gen.sv
module txw_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr_en,
  input  logic [ADDR_W-1:0] base_wr_data,
  input  logic              adv,
  input  logic              wrap,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] base_addr
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~{{(ADDR_W-2){1'b0}}, 2'b11};
  localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(STRIDE);

  logic [ADDR_W-1:0] aligned;
  assign aligned = base_wr_data & ALIGN_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
    end else if (base_wr_en) begin
      base_addr <= aligned;
      cur_addr  <= aligned;
    end else if (adv) begin
      cur_addr <= wrap ? base_addr : cur_addr + STEP;
    end
  end

  // R6: a base write lands aligned in both registers
  a_r6_base_load: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr_en |=> (cur_addr[1:0] == 2'b00) && (cur_addr == base_addr));

  // R5: a plain advance steps by one descriptor
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !base_wr_en) |=> cur_addr == $past(cur_addr) + STEP);

  // R5: a wrap advance returns to the base
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && wrap && !base_wr_en) |=> cur_addr == base_addr);
endmodule

// File: rtl/txw_len_acc.sv
module txw_len_acc #(
  parameter int LEN_W     = 16,
  parameter int MAX_FRAME = 2048
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] req_len,
  output logic [LEN_W-1:0] clip_len,
  output logic             clip_hit,
  input  logic             commit,
  input  logic [LEN_W-1:0] commit_len,
  input  logic             commit_last
);
  localparam int ACC_W = $clog2(MAX_FRAME + 1);
  localparam int CMP_W = (LEN_W > ACC_W) ? LEN_W : ACC_W;
  localparam logic [CMP_W-1:0] MAX_C = CMP_W'(MAX_FRAME);

  logic [CMP_W-1:0] acc;
  logic [CMP_W-1:0] room;
  logic [CMP_W-1:0] req_c;

  assign room     = MAX_C - acc;
  assign req_c    = CMP_W'(req_len);
  assign clip_hit = req_c > room;
  assign clip_len = clip_hit ? LEN_W'(room) : req_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc <= '0;
    else if (commit)
      acc <= commit_last ? '0 : acc + CMP_W'(commit_len);
  end

  // R2: running length never passes the frame limit
  a_r2_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= MAX_C);

  // R3: a closing buffer empties the accumulator
  a_r3_last_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && commit_last) |=> acc == '0);
endmodule

// File: rtl/txw_ring_walker.sv
module txw_ring_walker
  import txw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_FRAME  = 2048,
  parameter int DESC_BYTES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_enable,
  input  logic                start_pulse,
  input  logic                base_wr_en,
  input  logic [ADDR_W-1:0]   base_wr_data,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DESC_W-1:0]   mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [DESC_W-1:0]   mem_rsp_rdata,
  output logic                seg_valid,
  input  logic                seg_ready,
  output logic [PTR_W-1:0]    seg_ptr,
  output logic [LEN_W-1:0]    seg_len,
  output logic                seg_last,
  output logic                evt_buf_done,
  output logic                evt_frame_done,
  output logic                evt_babble,
  output logic                busy
);
  txw_state_e         state;
  txw_desc_t          desc_q;
  txw_desc_t          rsp_desc;
  logic [LEN_W-1:0]   seg_len_q;
  logic               babble_q;
  logic               pending;
  logic               take;
  logic               wb_done;
  logic [ADDR_W-1:0]  cur_addr;
  logic [ADDR_W-1:0]  base_addr;
  logic [LEN_W-1:0]   clip_len;
  logic               clip_hit;
  txw_desc_t          wb_desc;

  assign rsp_desc = txw_desc_t'(mem_rsp_rdata);
  assign take     = (state == ST_IDLE) && pending;
  assign wb_done  = (state == ST_WB) && mem_req_ready;

  txw_start_ctl u_start (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_enable (ctrl_enable),
    .start_pulse (start_pulse),
    .take        (take),
    .pending     (pending)
  );

  txw_addr_gen #(
    .ADDR_W (ADDR_W),
    .STRIDE (DESC_BYTES)
  ) u_addr (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_wr_en   (base_wr_en),
    .base_wr_data (base_wr_data),
    .adv          (wb_done),
    .wrap         (desc_q.flags[FLAG_WRAP]),
    .cur_addr     (cur_addr),
    .base_addr    (base_addr)
  );

  txw_len_acc #(
    .LEN_W     (LEN_W),
    .MAX_FRAME (MAX_FRAME)
  ) u_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_len     (rsp_desc.len),
    .clip_len    (clip_len),
    .clip_hit    (clip_hit),
    .commit      (wb_done),
    .commit_len  (seg_len_q),
    .commit_last (desc_q.flags[FLAG_LAST])
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      desc_q         <= '0;
      seg_len_q      <= '0;
      babble_q       <= 1'b0;
      evt_buf_done   <= 1'b0;
      evt_frame_done <= 1'b0;
      evt_babble     <= 1'b0;
    end else begin
      evt_buf_done   <= 1'b0;
      evt_frame_done <= 1'b0;
      evt_babble     <= 1'b0;
      unique case (state)
        ST_IDLE: if (pending) state <= ST_RD_REQ;
        ST_RD_REQ: if (mem_req_ready) state <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rsp_valid) begin
            desc_q <= rsp_desc;
            if (!rsp_desc.flags[FLAG_READY]) begin
              state <= ST_IDLE;
            end else begin
              seg_len_q <= clip_len;
              babble_q  <= clip_hit;
              state     <= ST_SEG;
            end
          end
        end
        ST_SEG: if (seg_ready) state <= ST_WB;
        ST_WB: begin
          if (mem_req_ready) begin
            evt_buf_done   <= 1'b1;
            evt_frame_done <= desc_q.flags[FLAG_LAST];
            evt_babble     <= babble_q;
            state          <= ST_RD_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wb_desc = desc_q;
    wb_desc.flags[FLAG_READY] = 1'b0;
  end

  assign mem_req_valid = (state == ST_RD_REQ) || (state == ST_WB);
  assign mem_req_write = (state == ST_WB);
  assign mem_req_addr  = cur_addr;
  assign mem_req_wdata = wb_desc;
  assign seg_valid     = (state == ST_SEG);
  assign seg_ptr       = desc_q.ptr;
  assign seg_len       = seg_len_q;
  assign seg_last      = desc_q.flags[FLAG_LAST];
  assign busy          = (state != ST_IDLE);

  // R10: segment holds under back-pressure
  a_r10_seg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> seg_valid && $stable(seg_ptr) && $stable(seg_len) && $stable(seg_last));

  // R10: memory request holds under back-pressure
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata));

  // R4: written descriptor is never left ready
  a_r4_wb_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> !mem_req_wdata[FLAG_READY]);

  // R4: accepted write-back is followed by the buffer event
  a_r4_buf_event: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> evt_buf_done);

  // R3: frame event only with a buffer event
  a_r3_frame_with_buf: assert property (@(posedge clk) disable iff (!rst_n)
    evt_frame_done |-> evt_buf_done);

  // R1: no segment offered while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !seg_valid && !mem_req_valid);
endmodule

// File: tb/test_txw_ring_walker.sv
module test_txw_ring_walker;
  localparam int MAXF = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_enable = 1'b0;
  logic        start_pulse = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic        seg_valid;
  logic        seg_ready = 1'b0;
  logic [31:0] seg_ptr;
  logic [15:0] seg_len;
  logic        seg_last;
  logic        evt_buf_done, evt_frame_done, evt_babble, busy;

  always #2.5 clk = ~clk;

  txw_ring_walker #(.MAX_FRAME(MAXF)) i_txw_ring_walker (
    .clk(clk), .rst_n(rst_n), .ctrl_enable(ctrl_enable), .start_pulse(start_pulse),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_ptr(seg_ptr), .seg_len(seg_len), .seg_last(seg_last),
    .evt_buf_done(evt_buf_done), .evt_frame_done(evt_frame_done),
    .evt_babble(evt_babble), .busy(busy)
  );

  int checks = 0;
  int failures = 0;

  logic [63:0] mem [64];
  logic [63:0] mem_ref [64];

  logic [31:0] exp_rd [$];
  logic [48:0] exp_seg [$];
  logic [95:0] exp_wb [$];
  int exp_buf = 0, exp_frame = 0, exp_bab = 0;
  int obs_buf = 0, obs_frame = 0, obs_bab = 0, obs_rd = 0;
  logic [31:0] first_rd = '0;
  bit first_seen = 0;

  logic [31:0] ref_base = '0, ref_cur = '0;
  int ref_acc = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] mk(input logic [31:0] p, input int len,
                                     input bit r, input bit w, input bit l);
    logic [15:0] f;
    f = '0;
    f[15] = r; f[13] = w; f[11] = l;
    f[0] = 1'b1;
    return {p, 16'(len), f};
  endfunction

  task automatic put(input int idx, input logic [63:0] v);
    mem[idx] = v;
    mem_ref[idx] = v;
  endtask

  // reference pass over the mirror image
  task automatic ref_walk();
    for (int n = 0; n < 200; n++) begin
      logic [63:0] d;
      int len, room, sl;
      bit bab;
      exp_rd.push_back(ref_cur);
      d = mem_ref[ref_cur[8:3]];
      if (!d[15]) break;
      len = int'(d[31:16]);
      room = MAXF - ref_acc;
      bab = len > room;
      sl = bab ? room : len;
      exp_seg.push_back({d[63:32], 16'(sl), d[11]});
      d[15] = 1'b0;
      exp_wb.push_back({ref_cur, d});
      mem_ref[ref_cur[8:3]] = d;
      exp_buf++;
      if (d[11]) exp_frame++;
      if (bab) exp_bab++;
      ref_acc = d[11] ? 0 : ref_acc + sl;
      ref_cur = d[13] ? ref_base : ref_cur + 32'd8;
    end
  endtask

  task automatic set_base(input logic [31:0] v);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = v;
    @(negedge clk);
    base_wr_en = 1'b0;
    ref_base = v & ~32'd3;
    ref_cur = ref_base;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start_pulse = 1'b1;
    @(negedge clk);
    start_pulse = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (!busy && exp_rd.size() == 0) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic end_pass_checks();
    chk(exp_seg.size() == 0, "R9 segments missing", exp_seg.size(), 0);
    chk(exp_wb.size() == 0, "R4 writebacks missing", exp_wb.size(), 0);
    chk(obs_buf == exp_buf, "R4 buffer events", obs_buf, exp_buf);
    chk(obs_frame == exp_frame, "R3 frame events", obs_frame, exp_frame);
    chk(obs_bab == exp_bab, "R2 babble events", obs_bab, exp_bab);
  endtask

  // memory model and random back-pressure
  always @(posedge clk) begin
    mem_req_ready <= ($urandom % 4) != 0;
    seg_ready <= ($urandom % 3) != 0;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem[mem_req_addr[8:3]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= mem[mem_req_addr[8:3]];
      end
    end
  end

  // monitors
  logic        hold_seg = 0;
  logic [48:0] held_seg = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_seg)
        chk(seg_valid && {seg_ptr, seg_len, seg_last} == held_seg, "R10 seg hold",
            {seg_ptr, seg_len, seg_last}, held_seg);
      hold_seg <= seg_valid && !seg_ready;
      held_seg <= {seg_ptr, seg_len, seg_last};
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          if (exp_wb.size() == 0) chk(0, "R4 unexpected writeback", mem_req_addr, 0);
          else begin
            logic [95:0] e;
            e = exp_wb.pop_front();
            chk({mem_req_addr, mem_req_wdata} == e, "R4 writeback", {mem_req_addr, mem_req_wdata}, e);
          end
        end else begin
          obs_rd++;
          if (!first_seen) begin first_rd <= mem_req_addr; first_seen <= 1; end
          if (exp_rd.size() == 0) chk(0, "R1 unexpected fetch", mem_req_addr, 0);
          else begin
            logic [31:0] e;
            e = exp_rd.pop_front();
            chk(mem_req_addr == e, "R5 fetch address", mem_req_addr, e);
          end
        end
      end
      if (seg_valid && seg_ready) begin
        if (exp_seg.size() == 0) chk(0, "R1 unexpected segment", seg_ptr, 0);
        else begin
          logic [48:0] e;
          e = exp_seg.pop_front();
          chk({seg_ptr, seg_len, seg_last} == e, "R9 R2 R3 segment", {seg_ptr, seg_len, seg_last}, e);
        end
      end
      if (evt_buf_done) obs_buf++;
      if (evt_frame_done) obs_frame++;
      if (evt_babble) obs_bab++;
    end
  end

  task automatic run_all();
    int rd0;
    for (int i = 0; i < 64; i++) put(i, 64'd0);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !seg_valid && !mem_req_valid, "R11 idle outputs", {busy, seg_valid, mem_req_valid}, 0);
    chk(!evt_buf_done && !evt_frame_done && !evt_babble, "R11 events low",
        {evt_buf_done, evt_frame_done, evt_babble}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R7 start ignored while disabled
    put(0, mk(32'h100, 10, 1, 0, 1));
    rd0 = obs_rd;
    pulse_start();
    repeat (40) @(negedge clk);
    chk(obs_rd == rd0 && !busy, "R7 disabled start", obs_rd - rd0, 0);
    put(0, 64'd0);
    ctrl_enable = 1'b1;

    // R6 base alignment, R5 wrap, R1 stop
    set_base(32'h43);
    put(8,  mk(32'h1000, 100, 1, 0, 1));
    put(9,  mk(32'h2000, 200, 1, 0, 0));
    put(10, mk(32'h3000, 50,  1, 1, 1));
    first_seen = 0;
    ref_walk();
    pulse_start();
    wait_idle();
    end_pass_checks();
    chk(first_rd == 32'h40, "R6 aligned start", first_rd, 32'h40);

    // R1 pointer kept at the stop descriptor
    put(8, mk(32'h1100, 64, 1, 0, 1));
    first_seen = 0;
    ref_walk();
    pulse_start();
    wait_idle();
    end_pass_checks();
    chk(first_rd == 32'h40, "R1 resume address", first_rd, 32'h40);

    // R2 clipping and babble, R3 length reset
    set_base(32'h80);
    put(16, mk(32'h4000, 1000, 1, 0, 0));
    put(17, mk(32'h5000, 1000, 1, 0, 0));
    put(18, mk(32'h6000, 1000, 1, 0, 0));
    put(19, mk(32'h7000, 1000, 1, 0, 1));
    put(20, mk(32'h8000, 300,  1, 0, 1));
    put(21, 64'd0);
    begin
      int b0, f0;
      b0 = obs_bab; f0 = obs_frame;
      ref_walk();
      pulse_start();
      wait_idle();
      end_pass_checks();
      chk(obs_bab - b0 == 2, "R2 babble count", obs_bab - b0, 2);
      chk(obs_frame - f0 == 2, "R3 frame count", obs_frame - f0, 2);
    end

    // R8 start during a pass gives one more pass
    set_base(32'hC0);
    for (int i = 0; i < 4; i++) put(24 + i, mk(32'h9000 + i, 20 + i, 1, 0, i == 3));
    put(28, 64'd0);
    rd0 = obs_rd;
    ref_walk();
    ref_walk();
    pulse_start();
    @(negedge clk);
    pulse_start();
    wait_idle();
    end_pass_checks();
    chk(obs_rd - rd0 == 6, "R8 extra pass fetches", obs_rd - rd0, 6);

    // random rings
    for (int it = 0; it < 30; it++) begin
      int b, k;
      b = $urandom % 40;
      k = $urandom % 12;
      set_base(32'(b * 8) | ($urandom % 4));
      for (int j = 0; j < k; j++)
        put(b + j, mk($urandom, $urandom % 1400, ($urandom % 8) != 0,
                      (j == k - 1) && ($urandom % 2 == 0), ($urandom % 5) < 2));
      put(b + k, mk($urandom, 5, 0, 0, 0));
      ref_walk();
      pulse_start();
      if ($urandom % 3 == 0) begin
        ref_walk();
        @(negedge clk);
        pulse_start();
      end
      wait_idle();
      end_pass_checks();
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule